// File: doc/BRIEF.md
# Flash Lock-Bit Command Sequencer

This block is the command front end of a block-protected parallel flash model. Bus write cycles carry 8-bit command codes. The block decodes one- and two-cycle command sequences. It keeps one protection bit per block plus a single master protection bit. It decides whether an erase, program, lock-set or lock-clear request may run.

An accepted request holds the part busy for a programmable number of clock cycles, and its effect on the protection bits lands when that period ends. A refused, malformed or interrupted request records sticky error flags in an 8-bit status byte. A ready output mirrors the busy flag.

The array contents, analog voltage sensing and real operation timing lie outside the block. Two qualifier inputs stand in for the voltage sensing: one says the program supply is valid, the other says the reset pin is held at the high override level. An abort input stands in for an interruption.

Top module: `flash_lock_seq`

## Requirements
- R1: After reset, status_o is 0x80, rdy_o is 1, rd_status_o is 0 (array read mode), and lock_o and master_o are 0.
- R2: When idle, command 0xFF selects array read mode (rd_status_o = 0). Command 0x70 selects status read mode (rd_status_o = 1). Each setup command (0x20 erase, 0x40 program, 0x60 lock) also selects status read mode, and the mode then holds until another mode-changing command is written.
- R3: An accepted request drives rdy_o and status_o[7] to 0 in the cycle after its confirm write. They stay 0 for exactly max(busy_len_i, 1) cycles and then return to 1.
- R4: Erase (0x20 then 0xD0) and program (0x40 then any byte) address block wr_blk_i in the second cycle. If that block's lock bit is 1 and rp_hv_i is 0, the request is refused without a busy period: erase sets SR.5 and SR.1, program sets SR.4 and SR.1. When rp_hv_i is 1, the request runs.
- R5: Lock set (0x60 then 0x01) sets the lock bit of block wr_blk_i when the busy period ends. It is refused, setting SR.4 and SR.1, when master_o is 1 and rp_hv_i is 0.
- R6: Master set (0x60 then 0xF1) sets master_o when the busy period ends, and only when rp_hv_i is 1. Otherwise it sets SR.4 and SR.1. No command ever returns master_o to 0.
- R7: Lock clear (0x60 then 0xD0) zeroes every block lock bit together when the busy period ends, and leaves them unchanged before that. When master_o is 1 and rp_hv_i is 0, it is refused: SR.5 and SR.1 are set and the locks are unchanged. When master_o is 0, rp_hv_i has no effect.
- R8: If vpp_ok_i is 0 at the confirm write, the request is refused with SR.3 plus SR.5 (erase, clear) or SR.4 (program, lock set, master set), and with SR.1 left alone even when protection would also refuse it.
- R9: After erase setup, any code other than 0xD0 is an invalid sequence. After lock setup, any code other than 0x01, 0xF1 or 0xD0 is an invalid sequence. An invalid sequence sets SR.4 and SR.5, starts no operation, and leaves status read mode selected.
- R10: SR.1, SR.3, SR.4 and SR.5 are sticky until command 0x50 (clear status) is written while idle, which zeroes all four. Status bits 6, 2 and 0 always read 0.
- R11: While busy, every write is ignored except 0x70, so neither a mode change nor a new sequence takes effect.
- R12: abort_i = 1 or vpp_ok_i = 0 during a busy cycle ends the operation at that clock edge, sets SR.3 plus the request's own error bit, and applies no effect. When this falls on the cycle that would complete the request, the abort wins. An aborted clear loads the lock bits with a nonzero pseudo-random pattern, and a repeated clear zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd_i | input | 8 | Command code or program data |
| wr_blk_i | input | BLK_W | Block addressed by the write |
| busy_len_i | input | BUSY_W | Busy period in cycles (0 acts as 1) |
| vpp_ok_i | input | 1 | Program supply valid |
| rp_hv_i | input | 1 | Reset pin at high override level |
| abort_i | input | 1 | Interrupts a running operation |
| status_o | output | 8 | Status byte |
| rdy_o | output | 1 | Ready (1) / busy (0) |
| rd_status_o | output | 1 | 1 = reads return status, 0 = array |
| lock_o | output | NUM_BLOCKS | Block lock bits |
| master_o | output | 1 | Master lock bit |

## Verification
Completion of a busy period and an abort can land on the same clock edge, and the bench provokes this by raising abort_i exactly in the final busy cycle of a lock-set request. It judges the outcome at the ports: the block lock bit must stay 0, status must carry SR.3 and SR.4, and ready must have returned. A second case of the same kind drops vpp_ok_i in the middle of a busy period of a program request, and a third places writes inside a busy window and requires them to leave no trace once the window closes.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE_SU = 8'h20;
  localparam logic [7:0] CMD_PROG_SU  = 8'h40;
  localparam logic [7:0] CMD_LOCK_SU  = 8'h60;
  localparam logic [7:0] CMD_GO       = 8'hD0;
  localparam logic [7:0] CMD_LK_BLK   = 8'h01;
  localparam logic [7:0] CMD_LK_MST   = 8'hF1;

  // sticky error vector positions
  localparam int ERR_PROT = 0;  // SR.1
  localparam int ERR_VLOW = 1;  // SR.3
  localparam int ERR_WR   = 2;  // SR.4
  localparam int ERR_ERS  = 3;  // SR.5

  typedef enum logic [2:0] {OP_NONE, OP_ERASE, OP_PROG, OP_SETBLK, OP_SETMST, OP_CLR} op_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE, SEQ_PROG, SEQ_LOCK} seq_e;

  function automatic logic [3:0] op_err(op_e op);
    logic [3:0] e;
    e = '0;
    case (op)
      OP_ERASE, OP_CLR:               e[ERR_ERS] = 1'b1;
      OP_PROG, OP_SETBLK, OP_SETMST:  e[ERR_WR]  = 1'b1;
      default: ;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import flash_lock_pkg::*;
(
  input  op_e        op_i,
  input  logic       blk_lock_i,
  input  logic       master_i,
  input  logic       rp_hv_i,
  input  logic       vpp_ok_i,
  output logic       ok_o,
  output logic [3:0] err_o
);
  logic blocked;

  always_comb begin
    case (op_i)
      OP_ERASE, OP_PROG: blocked = blk_lock_i & ~rp_hv_i;
      OP_SETBLK, OP_CLR: blocked = master_i & ~rp_hv_i;
      OP_SETMST:         blocked = ~rp_hv_i;
      default:           blocked = 1'b0;
    endcase
  end

  always_comb begin
    err_o = '0;
    ok_o  = 1'b0;
    if (op_i != OP_NONE) begin
      if (!vpp_ok_i) begin
        // supply fault takes precedence over protection
        err_o = op_err(op_i);
        err_o[ERR_VLOW] = 1'b1;
      end else if (blocked) begin
        err_o = op_err(op_i);
        err_o[ERR_PROT] = 1'b1;
      end else begin
        ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_lock_timer.sv
module flash_lock_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             quit_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = busy_q;
  assign quit_o = busy_q & abort_i;
  assign done_o = busy_q & ~abort_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (quit_o || done_o) busy_q <= 1'b0;
      else                  cnt_q  <= cnt_q - CNT_W'(1);
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= (len_i == '0) ? CNT_W'(1) : len_i;
    end
  end
endmodule

// File: rtl/flash_lock_scramble.sv
module flash_lock_scramble #(
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] pat_o
);
  localparam int          LFSR_W = 16;
  localparam logic [15:0] TAPS   = 16'hB400;
  localparam logic [15:0] SEED   = 16'hACE1;

  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_pat
    assign pat_o[i] = lfsr_q[i % LFSR_W];
  end
endmodule

// File: rtl/flash_lock_seq.sv
module flash_lock_seq
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BUSY_W     = 8,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_cmd_i,
  input  logic [BLK_W-1:0]      wr_blk_i,
  input  logic [BUSY_W-1:0]     busy_len_i,
  input  logic                  vpp_ok_i,
  input  logic                  rp_hv_i,
  input  logic                  abort_i,
  output logic [7:0]            status_o,
  output logic                  rdy_o,
  output logic                  rd_status_o,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic                  master_o
);
  seq_e                  seq_q, seq_d;
  op_e                   op_q, req_op;
  logic                  mode_q, mode_d;
  logic [3:0]            err_q, err_d, guard_err;
  logic [NUM_BLOCKS-1:0] lock_q, scramble;
  logic [BLK_W-1:0]      blk_q;
  logic                  master_q, busy, done, quit, start, inv_seq, clr_err;

  flash_lock_guard u_guard (
    .op_i      (req_op),
    .blk_lock_i(lock_q[wr_blk_i]),
    .master_i  (master_q),
    .rp_hv_i   (rp_hv_i),
    .vpp_ok_i  (vpp_ok_i),
    .ok_o      (start),
    .err_o     (guard_err)
  );

  flash_lock_timer #(.CNT_W(BUSY_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .len_i  (busy_len_i),
    .abort_i(abort_i | ~vpp_ok_i),
    .busy_o (busy),
    .done_o (done),
    .quit_o (quit)
  );

  flash_lock_scramble #(.OUT_W(NUM_BLOCKS)) u_scramble (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pat_o (scramble)
  );

  // command decode
  always_comb begin
    seq_d   = seq_q;
    mode_d  = mode_q;
    req_op  = OP_NONE;
    inv_seq = 1'b0;
    clr_err = 1'b0;
    if (wr_en_i && busy) begin
      if (wr_cmd_i == CMD_RD_STAT) mode_d = 1'b1;
    end else if (wr_en_i) begin
      seq_d = SEQ_IDLE;
      case (seq_q)
        SEQ_IDLE: begin
          case (wr_cmd_i)
            CMD_RD_ARRAY: mode_d = 1'b0;
            CMD_RD_STAT:  mode_d = 1'b1;
            CMD_CLR_STAT: clr_err = 1'b1;
            CMD_ERASE_SU: begin seq_d = SEQ_ERASE; mode_d = 1'b1; end
            CMD_PROG_SU:  begin seq_d = SEQ_PROG;  mode_d = 1'b1; end
            CMD_LOCK_SU:  begin seq_d = SEQ_LOCK;  mode_d = 1'b1; end
            default: ;
          endcase
        end
        SEQ_ERASE: begin
          if (wr_cmd_i == CMD_GO) req_op = OP_ERASE;
          else                    inv_seq = 1'b1;
        end
        SEQ_PROG: req_op = OP_PROG;
        SEQ_LOCK: begin
          case (wr_cmd_i)
            CMD_LK_BLK: req_op = OP_SETBLK;
            CMD_LK_MST: req_op = OP_SETMST;
            CMD_GO:     req_op = OP_CLR;
            default:    inv_seq = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    err_d = clr_err ? 4'b0 : err_q;
    err_d = err_d | guard_err;
    if (inv_seq) begin
      err_d[ERR_ERS] = 1'b1;
      err_d[ERR_WR]  = 1'b1;
    end
    if (quit) begin
      err_d = err_d | op_err(op_q);
      err_d[ERR_VLOW] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= SEQ_IDLE;
      mode_q   <= 1'b0;
      err_q    <= '0;
      op_q     <= OP_NONE;
      blk_q    <= '0;
      lock_q   <= '0;
      master_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
      err_q  <= err_d;
      if (start) begin
        op_q  <= req_op;
        blk_q <= wr_blk_i;
      end
      if (done) begin
        case (op_q)
          OP_SETBLK: lock_q[blk_q] <= 1'b1;
          OP_SETMST: master_q      <= 1'b1;
          OP_CLR:    lock_q        <= '0;
          default: ;
        endcase
      end else if (quit && op_q == OP_CLR) begin
        lock_q <= scramble;  // interrupted clear leaves an undefined pattern
      end
    end
  end

  assign rdy_o       = ~busy;
  assign rd_status_o = mode_q;
  assign lock_o      = lock_q;
  assign master_o    = master_q;
  assign status_o    = {~busy, 1'b0, err_q[ERR_ERS], err_q[ERR_WR],
                        err_q[ERR_VLOW], 1'b0, err_q[ERR_PROT], 1'b0};
endmodule

// File: rtl/flash_lock_seq_chk.sv
module flash_lock_seq_chk
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [7:0]            wr_cmd_i,
  input logic [7:0]            status_o,
  input logic                  rdy_o,
  input logic                  rd_status_o,
  input logic [NUM_BLOCKS-1:0] lock_o,
  input logic                  master_o
);
  assert_master_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |=> master_o);

  assert_err5_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !(wr_en_i && wr_cmd_i == CMD_CLR_STAT)) |=> status_o[5]);

  assert_err1_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !(wr_en_i && wr_cmd_i == CMD_CLR_STAT)) |=> status_o[1]);

  assert_busy_from_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(wr_en_i));

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |=> ($stable(lock_o) || rdy_o));

  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && wr_en_i && wr_cmd_i == CMD_RD_ARRAY) |=> rd_status_o);
endmodule

bind flash_lock_seq flash_lock_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_cmd_i   (wr_cmd_i),
  .status_o   (status_o),
  .rdy_o      (rdy_o),
  .rd_status_o(rd_status_o),
  .lock_o     (lock_o),
  .master_o   (master_o)
);

// File: tb/flash_lock_seq_tb.sv
module flash_lock_seq_tb_top;
  localparam int NB    = 16;
  localparam int BW    = $clog2(NB);
  localparam int LW    = 8;

  localparam logic [7:0] RDY = 8'h80, S5 = 8'h20, S4 = 8'h10, S3 = 8'h08, S1 = 8'h02;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    cmd = '0;
  logic [BW-1:0] blk = '0;
  logic [LW-1:0] busy_len = 8'd2;
  logic          vpp_ok = 1'b1;
  logic          rp_hv = 1'b0;
  logic          abort = 1'b0;
  logic [7:0]    status;
  logic          rdy, rd_status, master;
  logic [NB-1:0] lock;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [NB-1:0] lock_exp;

  always #2 clk = ~clk;  // 250 MHz

  flash_lock_seq #(.NUM_BLOCKS(NB), .BUSY_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(cmd), .wr_blk_i(blk),
    .busy_len_i(busy_len), .vpp_ok_i(vpp_ok), .rp_hv_i(rp_hv), .abort_i(abort),
    .status_o(status), .rdy_o(rdy), .rd_status_o(rd_status), .lock_o(lock),
    .master_o(master)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c, input int b);
    @(negedge clk);
    wr_en = 1'b1; cmd = c; blk = BW'(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic clr_stat();
    wr(8'h50, 0);
    chk("R10 clear status", status, RDY);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, RDY);
    chk("R1 rdy", rdy, 1);
    chk("R1 mode", rd_status, 0);
    chk("R1 lock", lock, 0);
    chk("R1 master", master, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 modes
    wr(8'h70, 0); chk("R2 read status", rd_status, 1);
    wr(8'hFF, 0); chk("R2 read array", rd_status, 0);
    wr(8'h20, 0); chk("R2 erase setup mode", rd_status, 1);
    wr(8'hD0, 1);
    wait_rdy(n);
    wr(8'hFF, 0);

    // R5 + R3: lock even blocks with varied busy lengths
    lock_exp = '0;
    for (int b = 0; b < NB; b += 2) begin
      busy_len = LW'(b % 5);
      wr(8'h60, 0); wr(8'h01, b);
      chk("R3 busy after confirm", rdy, 0);
      chk("R3 sr7 busy", status[7], 0);
      wait_rdy(n);
      chk("R3 busy length", n, (b % 5 == 0) ? 1 : b % 5);
      lock_exp[b] = 1'b1;
      chk("R5 lock set", lock, lock_exp);
      chk("R5 status", status, RDY);
    end
    chk("R2 mode held", rd_status, 1);

    // R4 erase / program sweep, no override
    busy_len = 8'd2;
    for (int b = 0; b < NB; b++) begin
      wr(8'h20, 0); wr(8'hD0, b);
      if (lock_exp[b]) begin
        chk("R4 erase refused", status, RDY | S5 | S1);
        clr_stat();
      end else begin
        chk("R4 erase runs", rdy, 0);
        wait_rdy(n);
        chk("R4 erase ok", status, RDY);
      end
      wr(8'h40, 0); wr(8'(b), b);
      if (lock_exp[b]) begin
        chk("R4 program refused", status, RDY | S4 | S1);
        clr_stat();
      end else begin
        chk("R4 program runs", rdy, 0);
        wait_rdy(n);
        chk("R4 program ok", status, RDY);
      end
    end
    rp_hv = 1'b1;
    wr(8'h20, 0); wr(8'hD0, 2);
    chk("R4 override erase runs", rdy, 0);
    wait_rdy(n);
    chk("R4 override ok", status, RDY);
    rp_hv = 1'b0;

    // R8 supply invalid
    vpp_ok = 1'b0;
    wr(8'h20, 0); wr(8'hD0, 1);
    chk("R8 erase vlow", status, RDY | S5 | S3); clr_stat();
    wr(8'h20, 0); wr(8'hD0, 0);
    chk("R8 vlow precedence", status, RDY | S5 | S3); clr_stat();
    wr(8'h40, 0); wr(8'h5A, 1);
    chk("R8 program vlow", status, RDY | S4 | S3); clr_stat();
    wr(8'h60, 0); wr(8'hD0, 0);
    chk("R8 clear vlow", status, RDY | S5 | S3);
    chk("R8 locks kept", lock, lock_exp); clr_stat();
    vpp_ok = 1'b1;

    // R9 invalid sequences
    wr(8'h20, 0); wr(8'h33, 0);
    chk("R9 erase invalid", status, RDY | S5 | S4);
    chk("R9 mode", rd_status, 1);
    chk("R9 rdy", rdy, 1); clr_stat();
    wr(8'h60, 0); wr(8'h77, 0);
    chk("R9 lock invalid", status, RDY | S5 | S4);
    chk("R9 locks kept", lock, lock_exp);

    // R10 sticky
    wr(8'h70, 0); chk("R10 sticky rd status", status, RDY | S5 | S4);
    wr(8'hFF, 0); chk("R10 sticky rd array", status, RDY | S5 | S4);
    clr_stat();

    // R11 writes ignored while busy
    busy_len = 8'd20;
    wr(8'h20, 0); wr(8'hD0, 1);
    wr(8'hFF, 0);
    chk("R11 mode unchanged", rd_status, 1);
    wr(8'h60, 0); wr(8'hD0, 0);
    wait_rdy(n);
    chk("R11 clear ignored", lock, lock_exp);
    chk("R11 status", status, RDY);
    wr(8'h70, 0);
    chk("R11 idle after busy", rdy, 1);

    // R7 clear, master clear, no override needed
    busy_len = 8'd5;
    wr(8'h60, 0); wr(8'hD0, 0);
    @(negedge clk);
    chk("R7 locks held mid-busy", lock, lock_exp);
    wait_rdy(n);
    chk("R7 all cleared", lock, 0);
    lock_exp = '0;

    // R12 abort mid-clear
    busy_len = 8'd3;
    for (int b = 0; b < 4; b++) begin
      wr(8'h60, 0); wr(8'h01, b); wait_rdy(n);
    end
    busy_len = 8'd10;
    wr(8'h60, 0); wr(8'hD0, 0);
    repeat (2) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk("R12 abort ready", rdy, 1);
    chk("R12 abort status", status, RDY | S5 | S3);
    chk("R12 pattern nonzero", (lock != '0), 1);
    clr_stat();
    busy_len = 8'd2;
    wr(8'h60, 0); wr(8'hD0, 0); wait_rdy(n);
    chk("R12 repeat clear", lock, 0);
    // abort on the completing cycle wins
    busy_len = 8'd4;
    wr(8'h60, 0); wr(8'h01, 5);
    repeat (3) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk("R12 abort wins rdy", rdy, 1);
    chk("R12 abort wins lock", lock, 0);
    chk("R12 abort wins status", status, RDY | S4 | S3);
    clr_stat();
    // supply drop mid-program
    busy_len = 8'd8;
    wr(8'h40, 0); wr(8'h11, 3);
    @(negedge clk);
    vpp_ok = 1'b0; @(negedge clk); vpp_ok = 1'b1;
    chk("R12 vdrop status", status, RDY | S4 | S3);
    clr_stat();

    // R6 master
    busy_len = 8'd2;
    wr(8'h60, 0); wr(8'hF1, 0);
    chk("R6 master refused", status, RDY | S4 | S1);
    chk("R6 master still 0", master, 0); clr_stat();
    wr(8'h60, 0); wr(8'h01, 7); wait_rdy(n);
    lock_exp = 16'h0080;
    rp_hv = 1'b1;
    wr(8'h60, 0); wr(8'hF1, 0); wait_rdy(n);
    chk("R6 master set", master, 1);
    rp_hv = 1'b0;
    wr(8'h60, 0); wr(8'h01, 9);
    chk("R5 master blocks lock set", status, RDY | S4 | S1);
    chk("R5 lock unchanged", lock, lock_exp); clr_stat();
    rp_hv = 1'b1;
    wr(8'h60, 0); wr(8'h01, 9); wait_rdy(n);
    lock_exp[9] = 1'b1;
    chk("R5 override lock set", lock, lock_exp);
    rp_hv = 1'b0;
    wr(8'h60, 0); wr(8'hD0, 0);
    chk("R7 master blocks clear", status, RDY | S5 | S1);
    chk("R7 locks unchanged", lock, lock_exp); clr_stat();
    rp_hv = 1'b1;
    wr(8'h60, 0); wr(8'hD0, 0); wait_rdy(n);
    chk("R7 override clear", lock, 0);
    chk("R6 master survives clear", master, 1);
    rp_hv = 1'b0;
    chk("R10 fixed zero bits", status & 8'h45, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule